// File: doc/BRIEF.md
# Byte-Serial Cipher Key Schedule Generator

This block turns a 128-, 192- or 256-bit cipher key into the complete round-key schedule of the AES block cipher. Software writes the key bytes one at a time into a small initial-key area. It then picks the key length and pulses `start`. The engine fills the remaining schedule words one byte per clock. Every byte passes through a single shared substitution box and XOR path, so there is one S-box and one byte adder in total.

The schedule lives in a flat byte space. Byte `b` of schedule word `w` sits at address `4*w + b`, where byte 0 is the most significant byte of the word. Addresses below 32 form the initial-key area and addresses 32 to 239 form the extension area. A read port returns any byte combinationally. While the schedule is incomplete, `ready` stays low, so a decryption pass that walks the round keys from the last one backwards never starts on a partial schedule.

The controller has three states:
- `ST_IDLE`: no valid schedule.
- `ST_EXPAND`: generating bytes; `busy` is high.
- `ST_READY`: the schedule is complete and held.

The transitions are:
- start accepted: `ST_IDLE`→`ST_EXPAND` and `ST_READY`→`ST_EXPAND`.
- last byte written: `ST_EXPAND`→`ST_READY`.
- key byte written: `ST_READY`→`ST_IDLE`.

Top module: `aes_keyexp_engine`

## Requirements
- R1: After reset, `ready` and `busy` are 0, and every address reads as 0x00.
- R2: When `busy` is 0, a write with `wr_en` stores `wr_data` at initial-area address `wr_addr` (0 to 31), and that byte reads back at the same address. A write presented while `busy` is 1 is ignored.
- R3: `key_size` selects the key length when start is accepted: 2'b00 gives 4 key words and 10 rounds, 2'b01 gives 6 words and 12 rounds, and 2'b10 or 2'b11 gives 8 words and 14 rounds.
- R4: After expansion, address `4*w+b` holds byte `b` (most significant byte first) of schedule word `w`, for all (rounds+1)*4 words. The schedule follows the standard expansion, including:
  - the round constants 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36;
  - the extra SubWord step applied to word positions 4 mod 8 for 8-word keys.
- R5: A start accepted at a clock edge raises `busy` and holds `ready` low. `ready` rises exactly 160, 184 or 208 clock edges later (for 4-, 6- or 8-word keys), which is one edge per generated byte. `busy` falls at that same edge.
- R6: A `start` presented while `busy` is 1 has no effect: neither the completion time nor the schedule changes.
- R7: While `ready` is 1, the schedule stays unchanged for as long as no key byte is written. A key byte written in this state clears `ready` at the next edge.
- R8: Read addresses 240 to 255 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Key byte write strobe |
| wr_addr | input | 5 | Initial-area byte address for key writes |
| wr_data | input | 8 | Key byte to write |
| key_size | input | 2 | Key length select (see R3) |
| start | input | 1 | Begin expansion (ignored while busy) |
| rd_addr | input | 8 | Schedule byte read address |
| rd_data | output | 8 | Schedule byte at `rd_addr` (combinational) |
| busy | output | 1 | Expansion in progress |
| ready | output | 1 | Complete schedule available |

## Verification
The bench builds the block with its default store split of 32 initial bytes and 208 extension bytes. That split is the smallest one that holds a 14-round schedule, so every key length runs to completion against the real memory bounds. With this configuration the bench can afford to sweep all 256 read addresses after reset and to compare every schedule byte for every key length. The expected values come from a word-level model whose S-box finds inverses by brute-force search. Disturbing starts and writes are injected in the middle of an expansion to show that they do not alter the result or the completion cycle.

// File: rtl/aes_ke_pkg.sv
package aes_ke_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXPAND = 2'd1,
        ST_READY  = 2'd2
    } ke_state_t;

    typedef enum logic [1:0] {
        MIX_PASS    = 2'd0,
        MIX_ROT_SUB = 2'd1,
        MIX_SUB     = 2'd2
    } ke_mix_t;

    localparam int unsigned BYTES_PER_WORD = 4;

    // Field multiply modulo x^8 + x^4 + x^3 + x + 1.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // Key length in words for a size select.
    function automatic logic [3:0] key_words(input logic [1:0] sz);
        unique case (sz)
            2'b00:   return 4'd4;
            2'b01:   return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

    // Total schedule words (rounds + 1) * 4.
    function automatic logic [5:0] sched_words(input logic [1:0] sz);
        unique case (sz)
            2'b00:   return 6'd44;
            2'b01:   return 6'd52;
            default: return 6'd60;
        endcase
    endfunction

    // Bytes the engine generates for a size select.
    function automatic logic [7:0] gen_bytes(input logic [1:0] sz);
        unique case (sz)
            2'b00:   return 8'd160;
            2'b01:   return 8'd184;
            default: return 8'd208;
        endcase
    endfunction

endpackage

// File: rtl/ke_sbox.sv
module ke_sbox
    import aes_ke_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    localparam logic [7:0] AFFINE_C = 8'h63;

    logic [7:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, p252, inv;

    // Multiplicative inverse as din^254 via an addition chain.
    always_comb begin
        p2   = gf_mul(din, din);
        p3   = gf_mul(p2, din);
        p6   = gf_mul(p3, p3);
        p12  = gf_mul(p6, p6);
        p15  = gf_mul(p12, p3);
        p30  = gf_mul(p15, p15);
        p60  = gf_mul(p30, p30);
        p120 = gf_mul(p60, p60);
        p240 = gf_mul(p120, p120);
        p252 = gf_mul(p240, p12);
        inv  = gf_mul(p252, p2);
    end

    for (genvar i = 0; i < 8; i++) begin : g_affine
        assign dout[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8]
                       ^ inv[(i + 6) % 8] ^ inv[(i + 7) % 8] ^ AFFINE_C[i];
    end

endmodule

// File: rtl/ke_round_byte.sv
module ke_round_byte
    import aes_ke_pkg::*;
(
    input  logic [7:0] prev_byte,
    input  logic [7:0] back_byte,
    input  ke_mix_t    mix,
    input  logic       first_byte,
    input  logic [7:0] rcon,
    output logic [7:0] new_byte
);
    logic [7:0] sub_byte;
    logic [7:0] temp;

    ke_sbox u_sbox (
        .din  (prev_byte),
        .dout (sub_byte)
    );

    always_comb begin
        unique case (mix)
            MIX_ROT_SUB: temp = sub_byte ^ (first_byte ? rcon : 8'h00);
            MIX_SUB:     temp = sub_byte;
            default:     temp = prev_byte;
        endcase
        new_byte = back_byte ^ temp;
    end

endmodule

// File: rtl/ke_byte_store.sv
module ke_byte_store #(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int NRD   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [7:0]              wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][7:0]     rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we && ({1'b0, waddr} < (AW + 1)'(DEPTH))) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = ({1'b0, raddr[p]} < (AW + 1)'(DEPTH)) ? mem[raddr[p]] : 8'h00;
    end

endmodule

// File: rtl/ke_ctrl.sv
module ke_ctrl
    import aes_ke_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_en,
    input  logic [1:0]        key_size,
    output logic              busy,
    output logic              ready,
    output logic              eng_we,
    output logic [ADDR_W-1:0] eng_waddr,
    output logic [ADDR_W-1:0] prev_addr,
    output logic [ADDR_W-1:0] back_addr,
    output ke_mix_t           mix,
    output logic              first_byte,
    output logic [7:0]        rcon
);
    localparam int WORD_W = ADDR_W - 2;

    ke_state_t         state, state_n;
    logic [WORD_W-1:0] word_q, last_word_q;
    logic [1:0]        byte_q;
    logic [2:0]        pos_q;
    logic [3:0]        nk_q;
    logic [7:0]        rcon_q;
    logic              start_ok, word_done, last_byte;
    logic [1:0]        src_byte;

    assign start_ok  = start && (state != ST_EXPAND);
    assign word_done = (byte_q == 2'd3);
    assign last_byte = word_done && (word_q == last_word_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start) state_n = ST_EXPAND;
            ST_EXPAND: if (last_byte) state_n = ST_READY;
            ST_READY: begin
                if (start)      state_n = ST_EXPAND;
                else if (wr_en) state_n = ST_IDLE;
            end
            default:   state_n = ST_IDLE;
        endcase
    end

    // Position counters and round constant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q      <= '0;
            last_word_q <= '0;
            byte_q      <= '0;
            pos_q       <= '0;
            nk_q        <= 4'd4;
            rcon_q      <= 8'h01;
        end else if (start_ok) begin
            word_q      <= WORD_W'(key_words(key_size));
            last_word_q <= WORD_W'(sched_words(key_size) - 6'd1);
            byte_q      <= '0;
            pos_q       <= '0;
            nk_q        <= key_words(key_size);
            rcon_q      <= 8'h01;
        end else if (state == ST_EXPAND) begin
            byte_q <= byte_q + 2'd1;
            if (word_done) begin
                word_q <= word_q + 1'b1;
                pos_q  <= ({1'b0, pos_q} == nk_q - 4'd1) ? 3'd0 : pos_q + 3'd1;
                if (pos_q == 3'd0) rcon_q <= xtime(rcon_q);
            end
        end
    end

    // Outputs
    always_comb begin
        busy  = (state == ST_EXPAND);
        ready = (state == ST_READY);
        eng_we = busy;
        if (pos_q == 3'd0)                       mix = MIX_ROT_SUB;
        else if (nk_q == 4'd8 && pos_q == 3'd4)  mix = MIX_SUB;
        else                                     mix = MIX_PASS;
        src_byte   = (mix == MIX_ROT_SUB) ? byte_q + 2'd1 : byte_q;
        first_byte = (byte_q == 2'd0);
        rcon       = rcon_q;
        eng_waddr  = {word_q, byte_q};
        prev_addr  = {word_q - WORD_W'(1), src_byte};
        back_addr  = {word_q - WORD_W'(nk_q), byte_q};
    end

endmodule

// File: rtl/aes_keyexp_engine.sv
module aes_keyexp_engine
    import aes_ke_pkg::*;
#(
    parameter int INIT_BYTES = 32,
    parameter int EXT_BYTES  = 208
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [4:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] key_size,
    input  logic       start,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       ready
);
    localparam int ADDR_W    = 8;
    localparam int INIT_AW   = $clog2(INIT_BYTES);
    localparam int TOTAL     = INIT_BYTES + EXT_BYTES;
    localparam int NRD       = 3;
    localparam int RP_EXT    = 0;
    localparam int RP_PREV   = 1;
    localparam int RP_BACK   = 2;

    logic              eng_we, first_byte;
    logic [ADDR_W-1:0] eng_waddr, prev_addr, back_addr;
    ke_mix_t           mix;
    logic [7:0]        rcon, new_byte;

    logic [NRD-1:0][ADDR_W-1:0]  rq_addr;
    logic [NRD-1:0][7:0]         rq_data;
    logic [NRD-1:0][INIT_AW-1:0] init_raddr;
    logic [NRD-1:0][7:0]         init_rdata;
    logic [NRD-1:0][ADDR_W-1:0]  ext_raddr;
    logic [NRD-1:0][7:0]         ext_rdata;

    logic               init_we, ext_we;
    logic [INIT_AW-1:0] init_waddr;
    logic [ADDR_W-1:0]  ext_waddr;
    logic [7:0]         st_wdata;

    ke_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wr_en      (wr_en),
        .key_size   (key_size),
        .busy       (busy),
        .ready      (ready),
        .eng_we     (eng_we),
        .eng_waddr  (eng_waddr),
        .prev_addr  (prev_addr),
        .back_addr  (back_addr),
        .mix        (mix),
        .first_byte (first_byte),
        .rcon       (rcon)
    );

    ke_round_byte u_round_byte (
        .prev_byte  (rq_data[RP_PREV]),
        .back_byte  (rq_data[RP_BACK]),
        .mix        (mix),
        .first_byte (first_byte),
        .rcon       (rcon),
        .new_byte   (new_byte)
    );

    // Write routing: engine owns the store while busy, the key port otherwise.
    always_comb begin
        init_we    = 1'b0;
        ext_we     = 1'b0;
        init_waddr = wr_addr;
        ext_waddr  = '0;
        st_wdata   = wr_data;
        if (busy) begin
            st_wdata = new_byte;
            if (eng_waddr < ADDR_W'(INIT_BYTES)) begin
                init_we    = eng_we;
                init_waddr = eng_waddr[INIT_AW-1:0];
            end else begin
                ext_we    = eng_we;
                ext_waddr = eng_waddr - ADDR_W'(INIT_BYTES);
            end
        end else begin
            init_we = wr_en;
        end
    end

    // Read routing for external, previous-word and Nk-back ports.
    assign rq_addr[RP_EXT]  = rd_addr;
    assign rq_addr[RP_PREV] = prev_addr;
    assign rq_addr[RP_BACK] = back_addr;

    for (genvar p = 0; p < NRD; p++) begin : g_rsel
        assign init_raddr[p] = rq_addr[p][INIT_AW-1:0];
        assign ext_raddr[p]  = rq_addr[p] - ADDR_W'(INIT_BYTES);
        assign rq_data[p] = (rq_addr[p] < ADDR_W'(INIT_BYTES)) ? init_rdata[p] :
                            ({1'b0, rq_addr[p]} < (ADDR_W + 1)'(TOTAL)) ? ext_rdata[p] : 8'h00;
    end

    assign rd_data = rq_data[RP_EXT];

    ke_byte_store #(.DEPTH(INIT_BYTES), .AW(INIT_AW), .NRD(NRD)) u_init_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (init_we),
        .waddr (init_waddr),
        .wdata (st_wdata),
        .raddr (init_raddr),
        .rdata (init_rdata)
    );

    ke_byte_store #(.DEPTH(EXT_BYTES), .AW(ADDR_W), .NRD(NRD)) u_ext_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ext_we),
        .waddr (ext_waddr),
        .wdata (st_wdata),
        .raddr (ext_raddr),
        .rdata (ext_rdata)
    );

endmodule

// File: rtl/ke_checker.sv
module ke_checker
    import aes_ke_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] key_size,
    input logic       start,
    input logic [7:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       ready
);
    logic [7:0] busy_cnt;
    logic [7:0] exp_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            exp_cnt  <= '0;
        end else if (start && !busy) begin
            busy_cnt <= '0;
            exp_cnt  <= gen_bytes(key_size);
        end else if (busy) begin
            busy_cnt <= busy_cnt + 8'd1;
        end
    end

    // R5: an accepted start enters expansion with ready low
    assert_start_enters_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !ready));

    // R5: ready only rises out of an expansion
    assert_ready_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(busy));

    // R5, R6: expansion always ends in ready after exactly one cycle per byte
    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ready && busy_cnt == exp_cnt));

    // R7: schedule held while no write or start arrives
    assert_ready_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start && !wr_en) |=> ready);

    // R7: held schedule reads stable
    assert_read_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready) && $stable(rd_addr)) |-> $stable(rd_data));

    // R7: a key write in the ready state clears ready
    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && !start) |=> !ready);

    always_comb begin
        if (rst_n) assert_flags_excl_R5: assert (!(busy && ready));
    end

endmodule

bind aes_keyexp_engine ke_checker u_ke_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .key_size (key_size),
    .start    (start),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .busy     (busy),
    .ready    (ready)
);

// File: tb/aes_keyexp_engine_tb.sv
module aes_keyexp_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] key_size = '0;
    logic       start = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, ready;

    int checks = 0;
    int errors = 0;

    logic [7:0]  key [32];
    logic [31:0] w   [60];

    always #2.5 clk = ~clk;

    aes_keyexp_engine u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .key_size(key_size), .start(start), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .ready(ready)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] x);
        logic [7:0] inv = 8'h00;
        logic [7:0] r;
        for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        r = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
            ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        return r;
    endfunction

    function automatic logic [31:0] m_subw(input logic [31:0] x);
        return {m_sbox(x[31:24]), m_sbox(x[23:16]), m_sbox(x[15:8]), m_sbox(x[7:0])};
    endfunction

    function automatic int nk_of(input logic [1:0] sz);
        return (sz == 2'b00) ? 4 : (sz == 2'b01) ? 6 : 8;
    endfunction

    task automatic build_model(input int nk);
        int total;
        logic [7:0]  rc;
        logic [31:0] t;
        total = 4 * (nk + 7);
        rc = 8'h01;
        for (int i = 0; i < nk; i++) w[i] = {key[4*i], key[4*i+1], key[4*i+2], key[4*i+3]};
        for (int i = nk; i < total; i++) begin
            t = w[i-1];
            if (i % nk == 0) begin
                t = m_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
            end else if (nk == 8 && i % nk == 4) begin
                t = m_subw(t);
            end
            w[i] = w[i-nk] ^ t;
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic load_key(input int mode, input int seed);
        logic [255:0] lit;
        lit = (mode == 0) ? 256'h2b7e151628aed2a6abf7158809cf4f3c_00000000000000000000000000000000 :
              (mode == 1) ? 256'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b_0000000000000000 :
                            256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
        for (int i = 0; i < 32; i++)
            key[i] = (seed == 0) ? lit[255 - 8*i -: 8] : (seed == 1) ? 8'h00 : 8'(i * 37 + seed * 11);
    endtask

    task automatic run(input logic [1:0] sz, input int seed, input bit disturb);
        int nk, nbytes, cnt;
        logic [7:0] d;
        logic [31:0] word;
        bit was_ready;
        nk = nk_of(sz);
        nbytes = 4 * (4 * (nk + 7) - nk);
        load_key((sz == 2'b11) ? 2 : int'(sz), seed);
        build_model(nk);
        was_ready = ready;
        for (int i = 0; i < 4 * nk; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 5'(i); wr_data = key[i];
            @(negedge clk);
            wr_en = 1'b0;
            if (i == 0 && was_ready) chk("R7", "ready after key write", {31'b0, ready}, 32'd0);
        end
        for (int i = 0; i < 4 * nk; i++) begin
            rd(8'(i), d);
            chk("R2", "key readback", {24'b0, d}, {24'b0, key[i]});
        end
        @(negedge clk);
        key_size = sz; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R5", "busy after start", {30'b0, busy, ready}, 32'd2);
        cnt = 0;
        while (!ready && cnt < 1000) begin
            if (disturb && cnt == 40) begin
                start = 1'b1; wr_en = 1'b1; wr_addr = 5'd0; wr_data = ~key[0];
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
        start = 1'b0; wr_en = 1'b0;
        chk(disturb ? "R6" : "R5", "cycles to ready", 32'(cnt), 32'(nbytes));
        chk("R5", "busy low at ready", {31'b0, busy}, 32'd0);
        for (int i = 0; i < 4 * (nk + 7); i++) begin
            for (int b = 0; b < 4; b++) begin
                rd(8'(4*i + b), d);
                word[31 - 8*b -: 8] = d;
            end
            chk(disturb ? "R2" : (sz == 2'b11 ? "R3" : "R4"), "schedule word", word, w[i]);
        end
        if (seed == 0) begin
            for (int b = 0; b < 4; b++) begin
                rd(8'(4*(4*(nk + 7) - 1) + b), d);
                word[31 - 8*b -: 8] = d;
            end
            chk("R4", "known last word", word,
                (nk == 4) ? 32'hb6630ca6 : (nk == 6) ? 32'h01002202 : 32'h706c631e);
        end
        repeat (10) @(negedge clk);
        chk("R7", "ready held", {31'b0, ready}, 32'd1);
        rd(8'(4*nk + 1), d);
        chk("R7", "schedule held", {24'b0, d}, {24'b0, w[nk][23:16]});
        for (int a = 240; a < 256; a++) begin
            rd(8'(a), d);
            chk("R8", "out of range read", {24'b0, d}, 32'd0);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        chk("R1", "ready/busy after reset", {30'b0, busy, ready}, 32'd0);
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), d);
            chk("R1", "reset byte", {24'b0, d}, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle flags", {30'b0, busy, ready}, 32'd0);
        for (int s = 0; s < 3; s++) begin
            run(2'(s), 0, 1'b0);
            run(2'(s), 1, 1'b0);
            run(2'(s), 2 + s, 1'b1);
        end
        run(2'b11, 0, 1'b0);
        summary();
    end

endmodule